// File: doc/BRIEF.md
# Fully Associative Translation Buffer Lookup

This block holds a set of address translations and searches all of them in parallel. Each entry carries a valid flag, an effective page number, a real page number, a 3-bit page-size code, an 8-bit process identifier and 8 attribute bits. A lookup request presents an effective address and the current process identifier. One cycle after the request is accepted, the block returns a response with four parts: a hit flag, the index of the matching entry, the translated physical address and the attributes of that entry. The block does no permission checking and no miss handling. A miss is only reported.

Lookups use a valid/ready request channel and a valid/ready response channel. The request side is ready whenever the response register is empty or is being drained in the same cycle. The response stays fixed while `rsp_valid` is high and `rsp_ready` is low. A stalled response also stalls new requests, which is the back-pressure path. Entries are loaded through a plain write port. A single-cycle invalidate pulse drops every entry.

The page-size code k selects a page of 1 KB times 4^k, from 1 KB (code 0) to 16 MB (code 7). The page offset is therefore 10+2k bits wide.

Top module: `etlb_lookup`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. No entry is valid, so the first lookup misses.
- R2: A cycle with `wr_en` high stores the given fields into entry `wr_idx` and marks that entry valid. Lookups that are accepted later see the new entry.
- R3: An entry that is not valid never matches. A miss returns `rsp_hit`=0, `rsp_idx` all ones (63 with 64 entries), `rsp_pa`=0 and `rsp_attr`=0.
- R4: Size code k gives mask = all ones shifted left by 10+2k. An entry matches only when (ea AND mask) equals the stored effective page number. A stored page number with bits set below the mask therefore never matches.
- R5: An entry whose stored process identifier is 0 matches any `req_pid`. Any other stored value matches only an equal `req_pid`.
- R6: On a hit, `rsp_pa` = (stored real page number AND mask) OR (ea AND NOT mask). `rsp_attr` carries the attributes of the hit entry, and `rsp_idx` its index.
- R7: When several entries match, the one with the lowest index is reported.
- R8: An `inv_all` pulse clears every valid flag in one cycle. If `wr_en` is high in the same cycle, the write is dropped.
- R9: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. The response is valid after that same edge. `req_ready` = !`rsp_valid` OR `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the response holds all of its values.
- R10: A request accepted in the same cycle as a write or an invalidate is answered from the table contents as they were before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Request can be accepted |
| req_ea | input | 32 | Effective address to translate |
| req_pid | input | 8 | Current process identifier |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | 1 when an entry matched |
| rsp_idx | output | 6 | Index of the matching entry, all ones on a miss |
| rsp_pa | output | 32 | Translated physical address, 0 on a miss |
| rsp_attr | output | 8 | Attributes of the matching entry, 0 on a miss |
| wr_en | input | 1 | Load an entry |
| wr_idx | input | 6 | Entry to load |
| wr_epn | input | 32 | Effective page number (address bits, offset zero) |
| wr_rpn | input | 32 | Real page number (address bits) |
| wr_size | input | 3 | Page-size code |
| wr_pid | input | 8 | Process identifier, 0 for shared |
| wr_attr | input | 8 | Attribute bits |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The bench loads overlapping pages of mixed sizes, so that one address matches several entries. A priority encoder that picks the highest index, or any index other than the lowest, would then return the wrong index and address. Directed cases cover four further faults: an address one byte past a page end, which a design with an off-by-one mask would wrongly hit; a shared entry with identifier 0 looked up under a foreign identifier; a private entry looked up under a wrong identifier, which a design that ignores the identifier would hit; and a write issued together with an invalidate, which a design that lets the write win would leave alive. Two timing cases are checked as well. A lookup issued in the same cycle as a write must see the old contents, and a design that forwards the new entry would hit too early. A stalled response must hold its values and keep `req_ready` low, and a design that overwrites the response would lose data.

// File: rtl/etlb_pkg.sv
package etlb_pkg;
  localparam int ADDR_W     = 32;
  localparam int PID_W      = 8;
  localparam int ATTR_W     = 8;
  localparam int SZ_W       = 3;
  localparam int BASE_SHIFT = 10;  // smallest page is 2^10 bytes
  localparam int SHIFT_STEP = 2;   // each size code is 4x larger

  typedef struct packed {
    logic [ADDR_W-1:0] epn;
    logic [ADDR_W-1:0] rpn;
    logic [SZ_W-1:0]   size;
    logic [PID_W-1:0]  pid;
    logic [ATTR_W-1:0] attr;
  } etlb_entry_t;

  // Mask keeping the page-number bits for a size code.
  function automatic logic [ADDR_W-1:0] page_mask(input logic [SZ_W-1:0] sz);
    int sh;
    sh = BASE_SHIFT + SHIFT_STEP * int'(sz);
    page_mask = {ADDR_W{1'b1}} << sh;
  endfunction
endpackage

// File: rtl/etlb_store.sv
module etlb_store
  import etlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  etlb_entry_t        wr_data,
  input  logic               inv_all,
  output logic [ENTRIES-1:0] valid_q,
  output etlb_entry_t        ent_q [ENTRIES]
);
  // Valid flags: invalidate has priority over a load in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (inv_all) begin
      valid_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= 1'b1;
    end
  end

  // Entry payload needs no reset; a cleared valid flag hides it.
  always_ff @(posedge clk) begin
    if (wr_en && !inv_all) begin
      ent_q[wr_idx] <= wr_data;
    end
  end

  AST_INV_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0)); // R8

  AST_LOAD_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all) |=> valid_q[$past(wr_idx)]); // R2
endmodule

// File: rtl/etlb_match.sv
module etlb_match
  import etlb_pkg::*;
#(
  parameter int ENTRIES = 64
) (
  input  logic [ENTRIES-1:0] valid_q,
  input  etlb_entry_t        ent_q [ENTRIES],
  input  logic [ADDR_W-1:0]  ea,
  input  logic [PID_W-1:0]   cur_pid,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic [ADDR_W-1:0] mask;
    logic              pid_ok;
    logic              page_ok;
    always_comb begin
      mask       = page_mask(ent_q[g].size);
      pid_ok     = (ent_q[g].pid == '0) || (ent_q[g].pid == cur_pid);
      page_ok    = ((ea & mask) == ent_q[g].epn);
      hit_vec[g] = valid_q[g] && pid_ok && page_ok;
    end
  end
endmodule

// File: rtl/etlb_pick.sv
module etlb_pick #(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] below;

  // Scan downward so the lowest set bit is the last assignment.
  always_comb begin
    any = 1'b0;
    idx = '1;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    below = ({{(ENTRIES-1){1'b0}}, 1'b1} << idx) - 1'b1;
    AST_PICK_IS_HIT: assert (!any || hit_vec[idx]); // R7
    AST_PICK_LOWEST: assert (!any || ((hit_vec & below) == '0)); // R7
  end
endmodule

// File: rtl/etlb_lookup.sv
module etlb_lookup
  import etlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [PID_W-1:0]  req_pid,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [ADDR_W-1:0] rsp_pa,
  output logic [ATTR_W-1:0] rsp_attr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_epn,
  input  logic [ADDR_W-1:0] wr_rpn,
  input  logic [SZ_W-1:0]   wr_size,
  input  logic [PID_W-1:0]  wr_pid,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic              inv_all
);
  etlb_entry_t        wr_data;
  etlb_entry_t        ent_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] hit_vec;
  logic               pick_any;
  logic [IDX_W-1:0]   pick_idx;
  etlb_entry_t        sel;
  logic [ADDR_W-1:0]  sel_mask;
  logic [ADDR_W-1:0]  xlate_pa;
  logic               accept;

  assign wr_data = '{epn: wr_epn, rpn: wr_rpn, size: wr_size, pid: wr_pid, attr: wr_attr};

  etlb_store #(.ENTRIES(ENTRIES)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .inv_all(inv_all), .valid_q(valid_q), .ent_q(ent_q)
  );

  etlb_match #(.ENTRIES(ENTRIES)) match_i (
    .valid_q(valid_q), .ent_q(ent_q), .ea(req_ea), .cur_pid(req_pid),
    .hit_vec(hit_vec)
  );

  etlb_pick #(.ENTRIES(ENTRIES)) pick_i (
    .hit_vec(hit_vec), .any(pick_any), .idx(pick_idx)
  );

  always_comb begin
    sel      = ent_q[pick_idx];
    sel_mask = page_mask(sel.size);
    xlate_pa = (sel.rpn & sel_mask) | (req_ea & ~sel_mask);
  end

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_idx   <= '1;
      rsp_pa    <= '0;
      rsp_attr  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= pick_any;
      rsp_idx   <= pick_any ? pick_idx : '1;
      rsp_pa    <= pick_any ? xlate_pa : '0;
      rsp_attr  <= pick_any ? sel.attr : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_idx)
                                   && $stable(rsp_pa) && $stable(rsp_attr))); // R9

  AST_MISS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_idx == '1 && rsp_pa == '0 && rsp_attr == '0)); // R3

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> valid_q[pick_idx]); // R3

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R9
endmodule

// File: tb/etlb_lookup_tb.sv
module etlb_lookup_tb_top;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_ea = '0;
  logic [7:0]  req_pid = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [5:0]  rsp_idx;
  logic [31:0] rsp_pa;
  logic [7:0]  rsp_attr;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [31:0] wr_epn = '0;
  logic [31:0] wr_rpn = '0;
  logic [2:0]  wr_size = '0;
  logic [7:0]  wr_pid = '0;
  logic [7:0]  wr_attr = '0;
  logic        inv_all = 1'b0;

  always #5 clk = ~clk;

  etlb_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ea(req_ea), .req_pid(req_pid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_pa(rsp_pa), .rsp_attr(rsp_attr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_epn(wr_epn), .wr_rpn(wr_rpn),
    .wr_size(wr_size), .wr_pid(wr_pid), .wr_attr(wr_attr), .inv_all(inv_all)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Reference table
  bit          m_valid [N];
  logic [31:0] m_epn [N];
  logic [31:0] m_rpn [N];
  logic [2:0]  m_size [N];
  logic [7:0]  m_pid [N];
  logic [7:0]  m_attr [N];

  // Expected response
  bit          e_hit;
  logic [5:0]  e_idx;
  logic [31:0] e_pa;
  logic [7:0]  e_attr;

  function automatic logic [31:0] mask_of(input logic [2:0] sz);
    logic [31:0] pg;
    pg = 32'd1 << (10 + 2 * int'(sz));
    return ~(pg - 32'd1);
  endfunction

  function automatic void predict(input logic [31:0] ea, input logic [7:0] pid);
    e_hit = 1'b0; e_idx = 6'h3f; e_pa = '0; e_attr = '0;
    for (int i = 0; i < N; i++) begin
      if (m_valid[i] && (m_pid[i] == 8'd0 || m_pid[i] == pid) &&
          ((ea & mask_of(m_size[i])) == m_epn[i])) begin
        e_hit  = 1'b1;
        e_idx  = 6'(i);
        e_pa   = (m_rpn[i] & mask_of(m_size[i])) | (ea & ~mask_of(m_size[i]));
        e_attr = m_attr[i];
        break;
      end
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_rsp(input string req);
    check(rsp_valid == 1'b1, req, "rsp_valid", 64'(rsp_valid), 64'd1);
    check(rsp_hit == e_hit && rsp_idx == e_idx && rsp_pa == e_pa && rsp_attr == e_attr,
          req, "hit/idx/pa/attr",
          {7'd0, rsp_hit, 2'd0, rsp_idx, rsp_pa, rsp_attr, 8'd0},
          {7'd0, e_hit, 2'd0, e_idx, e_pa, e_attr, 8'd0});
  endtask

  task automatic model_write(input int idx, input logic [31:0] epn, input logic [31:0] rpn,
                             input logic [2:0] sz, input logic [7:0] pid, input logic [7:0] attr);
    m_valid[idx] = 1'b1; m_epn[idx] = epn; m_rpn[idx] = rpn;
    m_size[idx] = sz; m_pid[idx] = pid; m_attr[idx] = attr;
  endtask

  task automatic drive_write(input int idx, input logic [31:0] epn, input logic [31:0] rpn,
                             input logic [2:0] sz, input logic [7:0] pid, input logic [7:0] attr);
    wr_en = 1'b1; wr_idx = 6'(idx); wr_epn = epn; wr_rpn = rpn;
    wr_size = sz; wr_pid = pid; wr_attr = attr;
  endtask

  task automatic write_entry(input int idx, input logic [31:0] epn, input logic [31:0] rpn,
                             input logic [2:0] sz, input logic [7:0] pid, input logic [7:0] attr);
    @(negedge clk);
    drive_write(idx, epn, rpn, sz, pid, attr);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(idx, epn, rpn, sz, pid, attr);
  endtask

  task automatic invalidate();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [7:0] pid, input string req);
    predict(ea, pid);
    @(negedge clk);
    req_valid = 1'b1; req_ea = ea; req_pid = pid;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(req);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] ea1;
    logic [31:0] ea2;
    bit          h1;
    logic [5:0]  i1;
    logic [31:0] p1;
    logic [7:0]  a1;
    void'($urandom(32'd20250117));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_epn[i] = '0; m_rpn[i] = '0;
      m_size[i] = '0; m_pid[i] = '0; m_attr[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: idle after reset, empty table
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'd1);
    lookup(32'h0000_0000, 8'd0, "R1");
    // R3: miss code on an empty table
    lookup(32'hdead_beef, 8'd3, "R3");

    // R2 and R6: 16 KB page (code 2) in entry 5
    write_entry(5, 32'h1234_4000, 32'habcd_ffff, 3'd2, 8'd7, 8'h5a);
    lookup(32'h1234_5678, 8'd7, "R2");
    check(rsp_pa == 32'habcd_d678, "R6", "translated address", 64'(rsp_pa), 64'habcd_d678);
    // R5: wrong process id misses, shared entry matches any id
    lookup(32'h1234_5678, 8'd8, "R5");
    write_entry(6, 32'h0040_0000, 32'h0080_0000, 3'd0, 8'd0, 8'h11);
    lookup(32'h0040_03ff, 8'd200, "R5");
    // R4: one byte past the 1 KB page misses
    lookup(32'h0040_0400, 8'd200, "R4");
    // R4: 16 MB page (code 7)
    write_entry(9, 32'h7f00_0000, 32'h0100_0000, 3'd7, 8'd0, 8'h22);
    lookup(32'h7fab_cdef, 8'd1, "R4");
    lookup(32'h80ab_cdef, 8'd1, "R4");
    // R4: epn with bits below the mask never matches
    write_entry(12, 32'h0050_0100, 32'h0, 3'd0, 8'd0, 8'h33);
    lookup(32'h0050_0100, 8'd0, "R4");

    // R7: overlapping entries 10 and 3 on the same page, lowest index wins
    write_entry(10, 32'h2000_0000, 32'h3000_0000, 3'd5, 8'd0, 8'h44);
    write_entry(3,  32'h2000_0000, 32'h4000_0000, 3'd3, 8'd0, 8'h55);
    lookup(32'h2000_1234, 8'd9, "R7");
    check(rsp_idx == 6'd3, "R7", "lowest index", 64'(rsp_idx), 64'd3);
    write_entry(3, 32'h2100_0000, 32'h4000_0000, 3'd3, 8'd0, 8'h55);
    lookup(32'h2000_1234, 8'd9, "R7");

    // R10: lookup issued together with a write sees the old contents
    predict(32'h6000_0010, 8'd0);
    @(negedge clk);
    req_valid = 1'b1; req_ea = 32'h6000_0010; req_pid = 8'd0;
    drive_write(20, 32'h6000_0000, 32'h6100_0000, 3'd1, 8'd0, 8'h66);
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check_rsp("R10");
    model_write(20, 32'h6000_0000, 32'h6100_0000, 3'd1, 8'd0, 8'h66);
    lookup(32'h6000_0010, 8'd0, "R10");

    // R9: response held under back-pressure, requests stalled
    predict(32'h1234_4abc, 8'd7);
    h1 = e_hit; i1 = e_idx; p1 = e_pa; a1 = e_attr;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_ea = 32'h1234_4abc; req_pid = 8'd7;
    @(negedge clk);
    req_ea = 32'h7f00_0001; req_pid = 8'd2;
    check_rsp("R9");
    check(req_ready == 1'b0, "R9", "req_ready while stalled", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    e_hit = h1; e_idx = i1; e_pa = p1; e_attr = a1;
    check_rsp("R9");
    predict(32'h7f00_0001, 8'd2);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp("R9");

    // R8: invalidate clears everything
    invalidate();
    lookup(32'h1234_5678, 8'd7, "R8");
    lookup(32'h7fab_cdef, 8'd1, "R8");
    // R8: write in the same cycle as invalidate is dropped
    @(negedge clk);
    inv_all = 1'b1;
    drive_write(0, 32'h0000_0000, 32'h0900_0000, 3'd7, 8'd0, 8'h77);
    @(negedge clk);
    inv_all = 1'b0; wr_en = 1'b0;
    lookup(32'h0000_1000, 8'd0, "R8");

    // Random phase: overlapping pages of mixed sizes
    for (int round = 0; round < 4; round++) begin
      invalidate();
      for (int k = 0; k < 40; k++) begin
        automatic int          idx = $urandom_range(0, N - 1);
        automatic logic [2:0]  sz  = 3'($urandom_range(0, 7));
        automatic logic [31:0] epn = $urandom & mask_of(sz);
        write_entry(idx, epn, $urandom, sz, 8'($urandom_range(0, 3)), 8'($urandom));
      end
      for (int k = 0; k < 120; k++) begin
        automatic int j = $urandom_range(0, N - 1);
        automatic logic [7:0] pid = 8'($urandom_range(0, 3));
        if (m_valid[j] && ($urandom_range(0, 3) != 0))
          ea1 = m_epn[j] | ($urandom & ~mask_of(m_size[j]));
        else
          ea1 = $urandom;
        if ($urandom_range(0, 1) == 1) pid = m_pid[j];
        lookup(ea1, pid, (k % 2 == 0) ? "R6" : "R7");
      end
    end
    ea2 = 32'h0;
    lookup(ea2, 8'd0, "R3");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule